// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

This block is the watchdog of a small microcontroller core. It counts ticks from one of three sources, chosen by a strap. The first is a free-running on-chip RC oscillator. The second is the instruction clock, which runs at the system clock divided by four. The third is a real-time-clock oscillator. The two oscillator inputs are asynchronous levels. Each passes through a synchroniser and an edge detector, and each rising edge counts as one tick. The instruction clock arrives as a one-cycle strobe in the core domain, and it stops while the core is halted. When the counter carries out of its top bit, the block asks for a reset. A running core gets a full-chip reset and the time-out flag is raised. A halted core gets only a warm reset, which restores the program counter and the stack pointer.

Software keeps the watchdog quiet with clear instructions. A strap chooses between two clear schemes. In the single scheme, one instruction clears the counter. In the paired scheme, two distinct instructions must both be seen before the counter clears. The halt instruction and the external reset also clear it. A software clear or a halt instruction clears only the top bit of the counter, so the next time-out falls between 2^(CNT_W-1) and 2^CNT_W ticks away. A disable strap freezes the whole function.

The paired scheme is a state machine with three states. PAIR_IDLE means nothing is pending. PAIR_HAVE_ONE means clear-1 has been seen. PAIR_HAVE_TWO means clear-2 has been seen. The machine moves along these transitions:
- *arm-one*: from PAIR_IDLE to PAIR_HAVE_ONE on clear-1 alone.
- *arm-two*: from PAIR_IDLE to PAIR_HAVE_TWO on clear-2 alone.
- *complete*: back to PAIR_IDLE with a clear, when the missing instruction arrives or both arrive in one cycle.
- *hold*: stay in place when the same instruction repeats or no strobe arrives.
- *abort*: back to PAIR_IDLE with no software clear, on a halt instruction, on the disable strap, or when the single scheme is chosen.

Top module: `wdt_guard`

## Requirements
- R1: `cfg_src` picks the tick source. 0 and 3 select the RC level `rc_lvl`, 2 selects the RTC level `rtc_lvl`, and 1 selects `instr_tick`. Each rising edge of a selected level counts as one tick once it has passed a two-flop synchroniser. For the instruction source, every cycle with `instr_tick` high counts as one tick.
- R2: After reset the counter is zero, and the 2^CNT_W-th tick overflows it. A software clear or a halt instruction zeroes only bit CNT_W-1 and keeps the lower bits. When a clear and a tick fall in the same cycle, the clear wins and the tick is lost.
- R3: When the counter overflows while `halted` is low, `chip_rst_req` is high for exactly one cycle, at the edge after the overflowing tick, and `to_flag` is set at that same edge.
- R4: When the counter overflows while `halted` is high, `warm_rst_req` pulses for one cycle, `chip_rst_req` stays low, and `to_flag` does not change.
- R5: When the instruction source is selected and `halted` is high, `instr_tick` is not counted.
- R6: With `cfg_paired`=0, a `clr_single` strobe clears the counter. `clr_one` and `clr_two` have no effect.
- R7: With `cfg_paired`=1, the clear happens only after both `clr_one` and `clr_two` have been seen, in either order or in the same cycle. Repeating the same one does not complete the pair, and `clr_single` has no effect.
- R8: A `halt_exec` strobe clears the counter's top bit, clears `to_flag` and drops any pending paired clear.
- R9: `to_flag` is cleared by `rst_n`, by `halt_exec` and by any successful software clear, and by nothing else.
- R10: While `cfg_disable` is 1, the counter neither counts nor overflows. `clr_single`, `clr_one`, `clr_two` and `halt_exec` have no effect, so `to_flag` keeps its value.
- R11: While `rst_n` is low, the counter, the pending state and `to_flag` are zero, and both reset request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low external reset, asynchronous assert |
| cfg_src | input | 2 | Tick source strap (0/3 RC, 1 instruction, 2 RTC) |
| cfg_paired | input | 1 | Clear scheme strap: 1 selects the paired clear |
| cfg_disable | input | 1 | Disable strap |
| rc_lvl | input | 1 | RC oscillator level, asynchronous |
| rtc_lvl | input | 1 | RTC oscillator level, asynchronous |
| instr_tick | input | 1 | Instruction clock strobe, one core cycle wide |
| halted | input | 1 | Core is in halt |
| clr_single | input | 1 | Single clear instruction strobe |
| clr_one | input | 1 | Paired clear-1 instruction strobe |
| clr_two | input | 1 | Paired clear-2 instruction strobe |
| halt_exec | input | 1 | Halt instruction strobe |
| chip_rst_req | output | 1 | Full-chip reset request pulse |
| warm_rst_req | output | 1 | Warm reset request pulse (PC and SP only) |
| to_flag | output | 1 | Time-out status flag |

## Verification
The assertions assume three things about the inputs:
- Instruction strobes are single core-cycle pulses.
- The two oscillator levels hold each value for at least two core cycles, so that no edge is lost in the synchroniser.
- The core cannot overflow through the instruction source while halted, which R5 guarantees.

The bench drives each oscillator as a square wave with a four-cycle period. It drives every strobe for exactly one cycle from the falling clock edge. In the random phases it uses only the instruction source, whose tick timing is exact cycle by cycle. Those phases let `halted`, the disable strap and the clear strobes vary freely within these limits.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    typedef enum logic [1:0] {
        SRC_RC     = 2'd0,
        SRC_INSTR  = 2'd1,
        SRC_RTC    = 2'd2,
        SRC_RC_ALT = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        PAIR_IDLE     = 2'd0,
        PAIR_HAVE_ONE = 2'd1,
        PAIR_HAVE_TWO = 2'd2
    } pair_state_e;

endpackage

// File: rtl/wdt_tick_sel.sv
module wdt_tick_sel
    import wdt_guard_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_src,
    input  logic       halted,
    input  logic       rc_lvl,
    input  logic       rtc_lvl,
    input  logic       instr_tick,
    output logic       tick
);

    localparam int N_ASYNC = 2;

    logic [N_ASYNC-1:0] async_lvl;
    logic [N_ASYNC-1:0] rise;
    tick_src_e          src;

    assign async_lvl = {rtc_lvl, rc_lvl};
    assign src       = tick_src_e'(cfg_src);

    // one synchroniser and rising-edge detector per asynchronous source
    for (genvar g = 0; g < N_ASYNC; g++) begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        logic                   last;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= '0;
                last  <= 1'b0;
            end else begin
                chain <= {chain[SYNC_STAGES-2:0], async_lvl[g]};
                last  <= chain[SYNC_STAGES-1];
            end
        end

        assign rise[g] = chain[SYNC_STAGES-1] & ~last;
    end

    always_comb begin
        unique case (src)
            SRC_INSTR:          tick = instr_tick & ~halted;
            SRC_RTC:            tick = rise[1];
            SRC_RC, SRC_RC_ALT: tick = rise[0];
        endcase
    end

    // R5: the stopped instruction clock yields no tick
    a_r5_halt_stops_instr: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_INSTR && halted) |-> !tick);

endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl
    import wdt_guard_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_disable,
    input  logic cfg_paired,
    input  logic clr_single,
    input  logic clr_one,
    input  logic clr_two,
    input  logic halt_exec,
    output logic sw_clear,
    output logic halt_clear
);

    pair_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PAIR_IDLE;
        else        state_q <= state_d;
    end

    // transitions: arm-one, arm-two, complete, hold, abort
    always_comb begin
        state_d = state_q;
        if (cfg_disable || !cfg_paired || halt_exec) begin
            state_d = PAIR_IDLE;
        end else begin
            unique case (state_q)
                PAIR_IDLE: begin
                    if (clr_one && clr_two) state_d = PAIR_IDLE;
                    else if (clr_one)       state_d = PAIR_HAVE_ONE;
                    else if (clr_two)       state_d = PAIR_HAVE_TWO;
                end
                PAIR_HAVE_ONE: if (clr_two) state_d = PAIR_IDLE;
                PAIR_HAVE_TWO: if (clr_one) state_d = PAIR_IDLE;
                default:       state_d = PAIR_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sw_clear   = 1'b0;
        halt_clear = halt_exec & ~cfg_disable;
        if (!cfg_disable) begin
            if (!cfg_paired) begin
                sw_clear = clr_single;
            end else begin
                unique case (state_q)
                    PAIR_IDLE:     sw_clear = clr_one & clr_two;
                    PAIR_HAVE_ONE: sw_clear = clr_two;
                    PAIR_HAVE_TWO: sw_clear = clr_one;
                    default:       sw_clear = 1'b0;
                endcase
            end
        end
    end

    // R7: a pending half-pair exists only under an enabled paired scheme
    a_r7_pending_needs_paired: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PAIR_IDLE) |-> $past(cfg_paired && !cfg_disable));

    // R8: a halt instruction leaves nothing pending
    a_r8_halt_drops_pending: assert property (@(posedge clk) disable iff (!rst_n)
        halt_exec |=> (state_q == PAIR_IDLE));

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_disable,
    input  logic halted,
    input  logic tick,
    input  logic clear,
    output logic chip_req,
    output logic warm_req,
    output logic to_flag
);

    localparam int MSB = CNT_W - 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   sum;

    assign sum = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            chip_req <= 1'b0;
            warm_req <= 1'b0;
            to_flag  <= 1'b0;
        end else begin
            chip_req <= 1'b0;
            warm_req <= 1'b0;
            if (clear) begin
                cnt_q[MSB] <= 1'b0;
                to_flag    <= 1'b0;
            end else if (tick && !cfg_disable) begin
                cnt_q <= sum[CNT_W-1:0];
                if (sum[CNT_W]) begin
                    if (halted) begin
                        warm_req <= 1'b1;
                    end else begin
                        chip_req <= 1'b1;
                        to_flag  <= 1'b1;
                    end
                end
            end
        end
    end

    // R2: a clear zeroes the top bit and keeps the lower bits
    a_r2_clear_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q[MSB] == 1'b0) && (cnt_q[MSB-1:0] == $past(cnt_q[MSB-1:0])));

    // R10: a disabled counter holds its value
    a_r10_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_disable) |-> (cnt_q == $past(cnt_q)));

    // R3: a full reset request comes only from a running core
    a_r3_chip_when_running: assert property (@(posedge clk) disable iff (!rst_n)
        chip_req |-> $past(!halted));

    // R4: a warm reset request comes only from a halted core
    a_r4_warm_when_halted: assert property (@(posedge clk) disable iff (!rst_n)
        warm_req |-> $past(halted));

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cfg_src,
    input  logic       cfg_paired,
    input  logic       cfg_disable,
    input  logic       rc_lvl,
    input  logic       rtc_lvl,
    input  logic       instr_tick,
    input  logic       halted,
    input  logic       clr_single,
    input  logic       clr_one,
    input  logic       clr_two,
    input  logic       halt_exec,
    output logic       chip_rst_req,
    output logic       warm_rst_req,
    output logic       to_flag
);

    logic tick;
    logic sw_clear;
    logic halt_clear;

    wdt_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_src    (cfg_src),
        .halted     (halted),
        .rc_lvl     (rc_lvl),
        .rtc_lvl    (rtc_lvl),
        .instr_tick (instr_tick),
        .tick       (tick)
    );

    wdt_clear_ctl u_clear (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_disable (cfg_disable),
        .cfg_paired  (cfg_paired),
        .clr_single  (clr_single),
        .clr_one     (clr_one),
        .clr_two     (clr_two),
        .halt_exec   (halt_exec),
        .sw_clear    (sw_clear),
        .halt_clear  (halt_clear)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_disable (cfg_disable),
        .halted      (halted),
        .tick        (tick),
        .clear       (sw_clear | halt_clear),
        .chip_req    (chip_rst_req),
        .warm_req    (warm_rst_req),
        .to_flag     (to_flag)
    );

    // R4: the two reset requests never coincide
    always @(posedge clk) begin
        if (rst_n) begin
            a_r4_requests_exclusive: assert (!(chip_rst_req && warm_rst_req));
        end
    end

    // R3: a full reset request is a single-cycle pulse that raises the flag
    a_r3_chip_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |=> !chip_rst_req);

    a_r3_chip_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        chip_rst_req |-> to_flag);

endmodule

// File: tb/wdt_guard_tb_top.sv
module wdt_guard_tb_top;

    localparam int W = 8;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_src;
    logic       cfg_paired, cfg_disable;
    logic       rc_lvl, rtc_lvl, instr_tick, halted;
    logic       clr_single, clr_one, clr_two, halt_exec;
    logic       chip_rst_req, warm_rst_req, to_flag;

    int checks = 0;
    int errors = 0;
    int chip_seen = 0;
    int warm_seen = 0;
    int base_c, base_w;

    // reference model state
    logic [W-1:0] m_cnt;
    int           m_pend;
    logic         m_flag, m_chip, m_warm;

    always #10 clk = ~clk;

    wdt_guard #(.CNT_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_paired(cfg_paired),
        .cfg_disable(cfg_disable), .rc_lvl(rc_lvl), .rtc_lvl(rtc_lvl),
        .instr_tick(instr_tick), .halted(halted), .clr_single(clr_single),
        .clr_one(clr_one), .clr_two(clr_two), .halt_exec(halt_exec),
        .chip_rst_req(chip_rst_req), .warm_rst_req(warm_rst_req), .to_flag(to_flag)
    );

    always @(negedge clk) begin
        if (rst_n === 1'b1 && chip_rst_req === 1'b1) chip_seen++;
        if (rst_n === 1'b1 && warm_rst_req === 1'b1) warm_seen++;
    end

    task automatic summary_and_end();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        summary_and_end();
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        instr_tick = 0; clr_single = 0; clr_one = 0; clr_two = 0; halt_exec = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle_inputs();
        rc_lvl = 0; rtc_lvl = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic strobe(input bit s, input bit o, input bit t, input bit h);
        clr_single = s; clr_one = o; clr_two = t; halt_exec = h;
        @(negedge clk);
        idle_inputs();
        @(negedge clk);
    endtask

    task automatic osc_edges(input int n, input bit use_rtc);
        for (int i = 0; i < n; i++) begin
            if (use_rtc) rtc_lvl = 1; else rc_lvl = 1;
            repeat (2) @(negedge clk);
            if (use_rtc) rtc_lvl = 0; else rc_lvl = 0;
            repeat (2) @(negedge clk);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic instr_run(input int n);
        instr_tick = 1;
        repeat (n) @(negedge clk);
        instr_tick = 0;
        repeat (2) @(negedge clk);
    endtask

    // expected next state for the instruction source, one clock edge ahead
    task automatic model_step();
        logic         sw, hh, clr, tk;
        logic [W:0]   s;
        int           np;
        sw = 0; np = m_pend;
        if (!cfg_disable) begin
            if (!cfg_paired) sw = clr_single;
            else if (m_pend == 0) begin
                if (clr_one && clr_two) sw = 1;
                else if (clr_one) np = 1;
                else if (clr_two) np = 2;
            end else if (m_pend == 1) sw = clr_two;
            else sw = clr_one;
        end
        if (sw || cfg_disable || !cfg_paired || halt_exec) np = 0;
        m_pend = np;
        hh  = halt_exec && !cfg_disable;
        clr = sw || hh;
        tk  = instr_tick && !halted && !cfg_disable;
        m_chip = 0; m_warm = 0;
        if (clr) begin
            m_cnt[W-1] = 1'b0;
            m_flag = 0;
        end else if (tk) begin
            s = {1'b0, m_cnt} + 1'b1;
            m_cnt = s[W-1:0];
            if (s[W]) begin
                if (halted) m_warm = 1;
                else begin m_chip = 1; m_flag = 1; end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        cfg_src = 2'd3; cfg_paired = 0; cfg_disable = 0; halted = 0;
        do_reset();

        // R11: state after reset
        chk("R11 chip_rst_req after reset", chip_rst_req, 0);
        chk("R11 warm_rst_req after reset", warm_rst_req, 0);
        chk("R11 to_flag after reset", to_flag, 0);

        // R1/R2/R3: RC source via code 3, overflow exactly at 2^W edges
        base_c = chip_seen; base_w = warm_seen;
        osc_edges((1 << W) - 1, 0);
        chk("R2 no overflow one edge early", chip_seen - base_c, 0);
        osc_edges(1, 0);
        chk("R1 R3 single chip pulse on RC overflow", chip_seen - base_c, 1);
        chk("R3 no warm pulse when running", warm_seen - base_w, 0);
        chk("R3 flag set on overflow", to_flag, 1);

        // R7: paired clear, repeat does not complete, single ignored
        cfg_paired = 1;
        strobe(0, 1, 0, 0);
        strobe(0, 1, 0, 0);
        chk("R7 repeated clear-1 does not clear", to_flag, 1);
        strobe(1, 0, 0, 0);
        chk("R7 single clear ignored in paired mode", to_flag, 1);
        strobe(0, 0, 1, 0);
        chk("R7 R9 pair completes and clears flag", to_flag, 0);

        // R4: RTC source while halted gives warm reset only
        cfg_src = 2'd2; halted = 1;
        base_c = chip_seen; base_w = warm_seen;
        osc_edges(1 << W, 1);
        chk("R1 R4 warm pulse on halted overflow", warm_seen - base_w, 1);
        chk("R4 no chip pulse when halted", chip_seen - base_c, 0);
        chk("R4 flag unchanged", to_flag, 0);

        // R2/R8: halt clear keeps lower bits (200 -> 72, 184 to overflow)
        base_w = warm_seen;
        osc_edges(200, 1);
        strobe(0, 0, 0, 1);
        osc_edges(183, 1);
        chk("R2 R8 no overflow before kept low bits run out", warm_seen - base_w, 0);
        osc_edges(1, 1);
        chk("R2 R8 overflow after kept low bits", warm_seen - base_w, 1);

        // R6/R10/R9: instruction source, single scheme, disable strap
        halted = 0; cfg_src = 2'd1; cfg_paired = 0;
        do_reset();
        base_c = chip_seen;
        instr_run(1 << W);
        chk("R1 R3 instruction overflow", chip_seen - base_c, 1);
        strobe(0, 1, 1, 0);
        chk("R6 paired strobes ignored in single mode", to_flag, 1);
        cfg_disable = 1;
        strobe(1, 0, 0, 0);
        strobe(0, 0, 0, 1);
        chk("R10 clears ignored while disabled", to_flag, 1);
        base_c = chip_seen;
        instr_run(400);
        chk("R10 no overflow while disabled", chip_seen - base_c, 0);
        cfg_disable = 0;
        strobe(1, 0, 0, 0);
        chk("R6 R9 single clear clears flag", to_flag, 0);

        // R5: halted instruction ticks are not counted
        halted = 1;
        base_c = chip_seen; base_w = warm_seen;
        instr_run(300);
        chk("R5 no pulses while halted", chip_seen - base_c + warm_seen - base_w, 0);
        halted = 0;
        instr_run((1 << W) - 1);
        chk("R5 counter held during halt", chip_seen - base_c, 0);
        instr_run(1);
        chk("R5 overflow after full run", chip_seen - base_c, 1);

        // R11: reset clears the flag
        rst_n = 0;
        @(negedge clk);
        chk("R11 flag cleared by reset", to_flag, 0);
        chk("R11 no request during reset", chip_rst_req | warm_rst_req, 0);

        // random phases against the model, instruction source only
        for (int ph = 0; ph < 4; ph++) begin
            int rate;
            rate = (ph < 2) ? 60 : 600;
            cfg_src = 2'd1; cfg_paired = ph[0]; cfg_disable = 0; halted = 0;
            do_reset();
            m_cnt = '0; m_pend = 0; m_flag = 0; m_chip = 0; m_warm = 0;
            for (int c = 0; c < 5000; c++) begin
                chk("R3 chip_rst_req vs model", chip_rst_req, m_chip);
                chk("R4 warm_rst_req vs model", warm_rst_req, m_warm);
                chk("R9 to_flag vs model", to_flag, m_flag);
                instr_tick  = ($urandom % 100) < 75;
                clr_single  = ($urandom % rate) == 0;
                clr_one     = ($urandom % rate) == 0;
                clr_two     = ($urandom % rate) == 0;
                halt_exec   = ($urandom % (rate * 4)) == 0;
                if (($urandom % 100) < 2) halted = ~halted;
                cfg_disable = ($urandom % 100) < 3;
                model_step();
                @(negedge clk);
            end
            idle_inputs();
        end

        summary_and_end();
    end

endmodule